// File: doc/BRIEF.md
# Self-Repairing Two-Rail Code Checker

This block watches two dual-rail signal pairs. In fault-free operation each pair carries a bit value on its true rail and the inverse of that value on its complement rail. A two-rail comparator folds the two pairs into one output pair. The output is a valid code word (01 or 10) only when both input pairs are complementary. When the comparator sees a non-code word, the block does not stop the system. It raises a reconfiguration flag in the same cycle and works out which single rail has failed. It then masks that rail and rebuilds it as the inverse of its surviving partner. A multiplexer passes the rebuilt rails downstream, together with the rails that are still healthy.

The choice of faulty rail uses the last corrected value of the pair. When a pair goes non-complementary, one rail has followed the data and the other has not. The rail that still holds its previous value is taken to be stuck. A sticky location register records every masked rail, and only a synchronous reset clears it. The block can absorb one masked rail per pair, so at most two faults in total.

A three-state controller tracks how much of the budget is used. The states are CLEAN (nothing masked), ONE (one pair repaired) and TWO (both pairs repaired). CLEAN goes to ONE when a single pair fails, and goes straight to TWO when both pairs fail in the same cycle. ONE goes to TWO when the remaining pair fails. TWO is held until reset, and reset always returns to CLEAN.

Top module: `tr_reconfig_checker`

## Requirements
- R1: After a synchronous reset, the fault location reads 0. With complementary inputs the reconfiguration flag is low, and the output rails equal the input rails.
- R2: The checker pair follows z0 = x0·x1 + y0·y1 and z1 = x0·y1 + y0·x1, evaluated on the output rails. For healthy data, z0 is 1 exactly when x0 equals x1.
- R3: The reconfiguration flag is high in the same cycle that a pair which is not yet repaired presents equal rails. This is the cycle in which the comparator on the pre-repair rails gives 00 or 11.
- R4: In a pair with equal rails, the rail whose value matches that pair's previous output value is marked faulty. After reset, each pair's previous value is x=0, y=1.
- R5: A masked rail is driven as the inverse of its partner input rail. This starts in the detection cycle and continues in every later cycle.
- R6: The 4-bit fault location is sticky. Bit 0 is x0, bit 1 is y0, bit 2 is x1 and bit 3 is y1. A new bit appears after the clock edge that ends the detection cycle, and only reset clears it.
- R7: One faulty rail per pair is absorbed, up to two in total, including both pairs failing in one cycle. The checker output stays a code word throughout.
- R8: Rails that are not masked pass from input to output unchanged.
- R9: Once a pair is repaired, any activity on its faulty rail causes no further flag and no change in the fault location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| x0_i | input | 1 | Pair 0 true rail |
| y0_i | input | 1 | Pair 0 complement rail |
| x1_i | input | 1 | Pair 1 true rail |
| y1_i | input | 1 | Pair 1 complement rail |
| x0_o | output | 1 | Pair 0 true rail after repair |
| y0_o | output | 1 | Pair 0 complement rail after repair |
| x1_o | output | 1 | Pair 1 true rail after repair |
| y1_o | output | 1 | Pair 1 complement rail after repair |
| z0_o | output | 1 | Checker output, first rail |
| z1_o | output | 1 | Checker output, second rail |
| recfg_en_o | output | 1 | Reconfiguration flag, high in a detection cycle |
| fault_loc_o | output | 4 | Sticky masked-rail map (bit0 x0, bit1 y0, bit2 x1, bit3 y1) |

## Verification
Detection and repair fall in the same cycle. A pair that has just gone non-complementary must raise the flag and must already show the corrected rail at the output, all before the edge that records the location. The bench provokes this with stuck rails that take the current data value when they are injected. The fault only shows at the next data flip, and one such flip hits both pairs at once. Each cycle is judged against the fault-free data and the checker formula applied to it, and the location is checked one edge later.

// File: rtl/tr_pkg.sv
package tr_pkg;
    localparam int NPAIR = 2;
    localparam int NRAIL = 2 * NPAIR;

    typedef struct packed {
        logic x;
        logic y;
    } rail_pair_t;

    typedef enum logic [1:0] {
        ST_CLEAN = 2'd0,
        ST_ONE   = 2'd1,
        ST_TWO   = 2'd2
    } heal_state_e;

    localparam rail_pair_t PAIR_RESET = '{x: 1'b0, y: 1'b1};
endpackage

// File: rtl/tr_rail_mux.sv
module tr_rail_mux
    import tr_pkg::*;
(
    input  rail_pair_t [NPAIR-1:0] raw_i,
    input  logic       [NRAIL-1:0] mask_i,
    output rail_pair_t [NPAIR-1:0] sel_o
);
    // a masked rail is rebuilt as the inverse of its partner
    always_comb begin
        for (int p = 0; p < NPAIR; p++) begin
            sel_o[p] = raw_i[p];
            if (mask_i[2*p])   sel_o[p].x = ~raw_i[p].y;
            if (mask_i[2*p+1]) sel_o[p].y = ~raw_i[p].x;
        end
    end
endmodule

// File: rtl/tr_two_rail_cmp.sv
module tr_two_rail_cmp
    import tr_pkg::*;
(
    input  rail_pair_t a_i,
    input  rail_pair_t b_i,
    output logic       z0_o,
    output logic       z1_o
);
    assign z0_o = (a_i.x & b_i.x) | (a_i.y & b_i.y);
    assign z1_o = (a_i.x & b_i.y) | (a_i.y & b_i.x);
endmodule

// File: rtl/tr_fault_locator.sv
module tr_fault_locator
    import tr_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  rail_pair_t [NPAIR-1:0] eff_i,
    input  rail_pair_t [NPAIR-1:0] fixed_i,
    output logic       [NRAIL-1:0] newm_o,
    output logic       [NPAIR-1:0] bad_o
);
    rail_pair_t [NPAIR-1:0] prev_q;

    // the rail that did not follow the data is the stuck one
    always_comb begin
        for (int p = 0; p < NPAIR; p++) begin
            bad_o[p]        = (eff_i[p].x == eff_i[p].y);
            newm_o[2*p]     = bad_o[p] & (eff_i[p].x == prev_q[p].x);
            newm_o[2*p+1]   = bad_o[p] & (eff_i[p].y == prev_q[p].y);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < NPAIR; p++) prev_q[p] <= PAIR_RESET;
        end else begin
            prev_q <= fixed_i;
        end
    end

    for (genvar p = 0; p < NPAIR; p++) begin : g_chk
        p_one_culprit_r4: assert property (@(posedge clk) disable iff (rst)
            bad_o[p] |-> $onehot(newm_o[2*p+1 -: 2]));
        p_history_valid_r4: assert property (@(posedge clk) disable iff (rst)
            prev_q[p].x != prev_q[p].y);
    end
endmodule

// File: rtl/tr_reconfig_checker.sv
module tr_reconfig_checker
    import tr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       x0_i,
    input  logic       y0_i,
    input  logic       x1_i,
    input  logic       y1_i,
    output logic       x0_o,
    output logic       y0_o,
    output logic       x1_o,
    output logic       y1_o,
    output logic       z0_o,
    output logic       z1_o,
    output logic       recfg_en_o,
    output logic [3:0] fault_loc_o
);
    heal_state_e state_q, state_d;
    logic [NRAIL-1:0] mask_q, mask_all, newm;
    logic [NPAIR-1:0] pair_bad;
    rail_pair_t [NPAIR-1:0] raw, eff, fixed;
    logic ez0, ez1;

    assign raw[0] = '{x: x0_i, y: y0_i};
    assign raw[1] = '{x: x1_i, y: y1_i};

    // rails with only the recorded masks applied
    tr_rail_mux u_pre_mux (.raw_i(raw), .mask_i(mask_q), .sel_o(eff));

    tr_two_rail_cmp u_pre_cmp (.a_i(eff[0]), .b_i(eff[1]), .z0_o(ez0), .z1_o(ez1));

    tr_fault_locator u_loc (
        .clk(clk), .rst(rst), .eff_i(eff), .fixed_i(fixed),
        .newm_o(newm), .bad_o(pair_bad)
    );

    assign mask_all = mask_q | newm;

    // final selection includes masks found in this cycle
    tr_rail_mux u_out_mux (.raw_i(raw), .mask_i(mask_all), .sel_o(fixed));

    tr_two_rail_cmp u_out_cmp (.a_i(fixed[0]), .b_i(fixed[1]), .z0_o(z0_o), .z1_o(z1_o));

    assign x0_o = fixed[0].x;
    assign y0_o = fixed[0].y;
    assign x1_o = fixed[1].x;
    assign y1_o = fixed[1].y;
    assign fault_loc_o = mask_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_CLEAN;
            mask_q  <= '0;
        end else begin
            state_q <= state_d;
            mask_q  <= mask_all;
        end
    end

    // flag and next state
    always_comb begin
        recfg_en_o = (ez0 == ez1);
        state_d    = state_q;
        unique case (state_q)
            ST_CLEAN: begin
                if (&pair_bad)      state_d = ST_TWO;
                else if (|pair_bad) state_d = ST_ONE;
            end
            ST_ONE:   if (|pair_bad) state_d = ST_TWO;
            ST_TWO:   state_d = ST_TWO;
            default:  state_d = ST_CLEAN;
        endcase
    end

    p_code_word_out_r7: assert property (@(posedge clk) disable iff (rst)
        z0_o != z1_o);
    p_loc_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((fault_loc_o & $past(fault_loc_o)) == $past(fault_loc_o)));
    p_flag_records_r3: assert property (@(posedge clk) disable iff (rst)
        recfg_en_o |=> (fault_loc_o != $past(fault_loc_o)));
    p_one_per_pair_r7: assert property (@(posedge clk) disable iff (rst)
        !(fault_loc_o[0] & fault_loc_o[1]) && !(fault_loc_o[2] & fault_loc_o[3]));
    p_pass_clean_r8: assert property (@(posedge clk) disable iff (rst)
        (fault_loc_o == 4'd0 && !recfg_en_o) |->
        ({x0_o, y0_o, x1_o, y1_o} == {x0_i, y0_i, x1_i, y1_i}));
    p_state_tracks_mask_r7: assert property (@(posedge clk) disable iff (rst)
        $countones(mask_q) == int'(state_q));
endmodule

// File: tb/sim_tr_reconfig_checker.sv
module sim_tr_reconfig_checker;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [3:0] raw_in = 4'b1010;  // bit0 x0, bit1 y0, bit2 x1, bit3 y1
    logic x0_o, y0_o, x1_o, y1_o, z0_o, z1_o, recfg_en_o;
    logic [3:0] fault_loc_o;

    tr_reconfig_checker u0 (
        .clk(clk), .rst(rst),
        .x0_i(raw_in[0]), .y0_i(raw_in[1]), .x1_i(raw_in[2]), .y1_i(raw_in[3]),
        .x0_o(x0_o), .y0_o(y0_o), .x1_o(x1_o), .y1_o(y1_o),
        .z0_o(z0_o), .z1_o(z1_o), .recfg_en_o(recfg_en_o), .fault_loc_o(fault_loc_o)
    );

    int n_checks = 0;
    int n_errors = 0;
    logic [3:0] gold = 4'b1010;
    logic [3:0] fault_en = '0;
    logic [3:0] fault_val = '0;
    logic [3:0] model_mask = '0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] ref_z(input logic [3:0] r);
        logic z0, z1;
        z0 = (r[0] & r[2]) | (r[1] & r[3]);
        z1 = (r[0] & r[3]) | (r[1] & r[2]);
        return {z0, z1};
    endfunction

    function automatic logic [3:0] rand_gold();
        logic a, b;
        a = 1'($urandom % 2);
        b = 1'($urandom % 2);
        return {~b, b, ~a, a};
    endfunction

    task automatic step(input logic [3:0] g, input bit wild);
        logic [3:0] newbits;
        logic exp_en;
        @(negedge clk);
        gold = g;
        if (wild) fault_val = (fault_val & ~model_mask) | (4'($urandom) & model_mask);
        raw_in = (gold & ~fault_en) | (fault_val & fault_en);
        #1;
        exp_en = 1'b0;
        newbits = '0;
        for (int p = 0; p < 2; p++) begin
            if (!model_mask[2*p] && !model_mask[2*p+1] && raw_in[2*p] == raw_in[2*p+1]) begin
                exp_en = 1'b1;
                newbits[2*p +: 2] = fault_en[2*p +: 2];
            end
        end
        chk(((model_mask | newbits) != 0) ? "R5" : "R8", "rails",
            {28'd0, y1_o, x1_o, y0_o, x0_o}, {28'd0, gold});
        chk("R2 R7", "checker", {30'd0, z0_o, z1_o}, {30'd0, ref_z(gold)});
        chk(wild ? "R9" : "R3", "flag", {31'd0, recfg_en_o}, {31'd0, exp_en});
        chk("R4 R6", "location", {28'd0, fault_loc_o}, {28'd0, model_mask});
        model_mask = model_mask | newbits;
    endtask

    task automatic do_reset(input string req);
        @(negedge clk);
        rst = 1'b1;
        fault_en = '0;
        fault_val = '0;
        gold = 4'b1010;
        raw_in = gold;
        @(negedge clk);
        rst = 1'b0;
        model_mask = '0;
        #1;
        chk(req, "reset location", {28'd0, fault_loc_o}, 32'd0);
        chk("R1", "reset flag", {31'd0, recfg_en_o}, 32'd0);
        chk("R1", "reset rails", {28'd0, y1_o, x1_o, y0_o, x0_o}, {28'd0, raw_in});
    endtask

    task automatic inject(input int r);
        fault_en[r] = 1'b1;
        fault_val[r] = gold[r];
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240517));
        do_reset("R1");
        for (int i = 0; i < 40; i++) step(rand_gold(), 1'b0);
        // directed R4: x0 stuck at 1, then data flips pair 0
        step(4'b1001, 1'b0);
        inject(0);
        step(4'b1010, 1'b0);
        chk("R3", "directed flag x0", {31'd0, recfg_en_o}, 32'd1);
        step(4'b1010, 1'b0);
        chk("R4", "directed loc x0", {28'd0, fault_loc_o}, 32'd1);
        for (int i = 0; i < 30; i++) step(rand_gold(), 1'b0);
        for (int i = 0; i < 20; i++) step(rand_gold(), 1'b1);
        inject(3);
        for (int i = 0; i < 40; i++) step(rand_gold(), 1'b0);
        chk("R7", "two faults recorded", {28'd0, fault_loc_o}, 32'd9);
        for (int i = 0; i < 20; i++) step(rand_gold(), 1'b1);
        do_reset("R6");
        // both pairs fail in the same cycle
        for (int i = 0; i < 10; i++) step(rand_gold(), 1'b0);
        inject(1);
        inject(2);
        step(gold ^ 4'b1111, 1'b0);
        chk("R7", "dual flag", {31'd0, recfg_en_o}, 32'd1);
        step(gold, 1'b0);
        chk("R7", "dual location", {28'd0, fault_loc_o}, 32'd6);
        for (int i = 0; i < 30; i++) step(rand_gold(), 1'b1);
        do_reset("R6");
        for (int i = 0; i < 30; i++) step(rand_gold(), 1'b0);
        summary();
        $finish;
    end
endmodule